// File: doc/BRIEF.md
# Two-Dimensional Parity Generator-Checker

This block protects a frame of 7-bit characters with a row-and-column parity scheme. Every character receives a parity bit of its own, and one extra check character is built from the parity of each of the eight bit positions taken across the whole frame. Because the column check runs beside the row check, two bits flipped inside one character are still caught, even though that character's own parity looks correct.

One instance serves both ends of a link, selected per frame. In generate mode it takes raw 7-bit characters and emits 8-bit coded characters, followed by the check character once the frame ends. In check mode it takes received 8-bit coded characters, with the check character marked as the last one. It then flags each character whose own parity is wrong, reports a per-position column syndrome, and holds a frame-level error flag. Odd or even parity is chosen by one input, and that choice applies to the rows and to the check character alike.

Top module: `lrc_codec`

## Requirements
- R1: In generate mode, one cycle after a character is accepted, `outValid` is 1 and `outData` holds the coded character. Bit 7 of the coded character is the parity bit and bits 6..0 are the data. The coded character has an odd number of ones when `oddSense` is 1 and an even number when `oddSense` is 0.
- R2: The data 7'b1110001 codes to 8'hF1 with odd sense and to 8'h71 with even sense.
- R3: In generate mode, the check character appears with `outIsCheck` set one cycle after the last coded character of the frame. For every bit position 7..0, that position across the coded characters and the check character together holds an odd number of ones (odd sense) or an even number (even sense).
- R4: An input presented as valid in the cycle after a generate-mode last character is dropped. It produces no coded output and leaves the check character unchanged, and `outValid` is 0 in the cycle after the check character.
- R5: The column accumulator restarts with the first character of each frame, so a check character depends only on the characters of its own frame.
- R6: In check mode, `rowErr` pulses one cycle after a data character whose count of ones does not match the selected sense. The check character, marked by `inLast`, is never row-checked.
- R7: In check mode, `colValid` pulses one cycle after the check character is received. `colSyndrome` bit i is 1 exactly when bit position i, over the frame's characters plus the check character, has the wrong parity.
- R8: Two flipped bits in one character leave `rowErr` at 0, and the syndrome flags exactly those two positions.
- R9: `frameErr` is set by any row error or any non-zero syndrome in a check-mode frame. It stays set until the first character of the next check-mode frame, which reloads it from that character's own row result.
- R10: After reset, `outValid`, `outIsCheck`, `rowErr`, `colValid`, `frameErr` and `colSyndrome` are all 0.
- R11: In check mode `outValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| modeCheck | input | 1 | 0 selects generate, 1 selects check; held for a whole frame |
| oddSense | input | 1 | 1 selects odd parity, 0 selects even; held for a whole frame |
| inValid | input | 1 | A character is presented this cycle |
| inLast | input | 1 | Marks the last data character (generate) or the check character (check) |
| inData | input | 8 | Generate: bits 6..0 carry data. Check: the received coded or check character |
| outValid | output | 1 | `outData` carries a coded or check character |
| outData | output | 8 | Coded character or check character |
| outIsCheck | output | 1 | The current output is the check character |
| rowErr | output | 1 | One-cycle pulse for a received character whose parity is wrong |
| colValid | output | 1 | One-cycle pulse when `colSyndrome` is updated |
| colSyndrome | output | 8 | Bit positions whose column parity failed |
| frameErr | output | 1 | Sticky error flag for the current or most recent check-mode frame |

## Verification
Every result is registered once. Coded characters, `rowErr` and `frameErr` are therefore due on the edge after the input is accepted, and the check character is due one edge later. `colValid` and `colSyndrome` are due on the edge after the check character. The bench drives inputs on the falling edge and samples on the next falling edge, so each sample lands exactly on the cycle a result is due. The check character and the dropped-input slot are read one and two falling edges after the last coded character. Expected codes come from a literal table, and expected check characters and syndromes are built by the bench from the column rule.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic accept;     // input character taken this cycle
    logic first;      // accepted character opens a frame
    logic lastIn;     // accepted character closes a frame
    logic emitCheck;  // output the check character this cycle
    logic checkMode;  // receive side is active
  } lrcStrobes_t;
endpackage

// File: rtl/lrc_ctrl.sv
module lrc_ctrl
  import lrc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        modeCheck,
  output lrcStrobes_t strobes
);
  logic inFrameQ;  // a frame has started and not yet ended
  logic slotQ;     // check-character slot after a generate-mode frame
  logic accept;

  assign accept = inValid && !slotQ;

  always_comb begin
    strobes.accept    = accept;
    strobes.first     = accept && !inFrameQ;
    strobes.lastIn    = accept && inLast;
    strobes.emitCheck = slotQ;
    strobes.checkMode = modeCheck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrameQ <= 1'b0;
      slotQ    <= 1'b0;
    end else begin
      if (accept) inFrameQ <= !inLast;
      slotQ <= accept && inLast && !modeCheck;
    end
  end
endmodule

// File: rtl/lrc_datapath.sv
module lrc_datapath
  import lrc_pkg::*;
#(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  lrcStrobes_t       strobes,
  input  logic              oddSense,
  input  logic [DATA_W:0]   inData,
  output logic              outValid,
  output logic [DATA_W:0]   outData,
  output logic              outIsCheck,
  output logic              rowErr,
  output logic              colValid,
  output logic [DATA_W:0]   colSyndrome,
  output logic              frameErr
);
  localparam int CODE_W = DATA_W + 1;

  logic [CODE_W-1:0] accQ;
  logic [CODE_W-1:0] coded;
  logic [CODE_W-1:0] word;
  logic [CODE_W-1:0] accBase;
  logic [CODE_W-1:0] senseMask;
  logic [CODE_W-1:0] synNext;
  logic              rowBad;
  logic              rowHit;
  logic              errBase;

  always_comb begin
    senseMask = {CODE_W{oddSense}};
    coded     = {(^inData[DATA_W-1:0]) ^ oddSense, inData[DATA_W-1:0]};
    word      = strobes.checkMode ? inData : coded;
    accBase   = strobes.first ? '0 : accQ;
    synNext   = accBase ^ inData ^ senseMask;
    rowBad    = (^inData) != oddSense;
    rowHit    = strobes.accept && strobes.checkMode && !strobes.lastIn && rowBad;
    errBase   = strobes.first ? 1'b0 : frameErr;
  end

  // column accumulator over every accepted character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               accQ <= '0;
    else if (strobes.accept) accQ <= accBase ^ word;
  end

  // generate-side output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outIsCheck <= 1'b0;
    end else begin
      outValid   <= (strobes.accept && !strobes.checkMode) || strobes.emitCheck;
      outIsCheck <= strobes.emitCheck;
      if (strobes.emitCheck)
        outData <= accQ ^ senseMask;
      else if (strobes.accept && !strobes.checkMode)
        outData <= coded;
    end
  end

  // check-side results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowErr      <= 1'b0;
      colValid    <= 1'b0;
      colSyndrome <= '0;
      frameErr    <= 1'b0;
    end else begin
      rowErr   <= rowHit;
      colValid <= strobes.accept && strobes.checkMode && strobes.lastIn;
      if (strobes.accept && strobes.checkMode) begin
        if (strobes.lastIn) begin
          colSyndrome <= synNext;
          frameErr    <= errBase | (|synNext);
        end else begin
          frameErr    <= errBase | rowHit;
        end
      end
    end
  end
endmodule

// File: rtl/lrc_codec.sv
module lrc_codec
  import lrc_pkg::*;
#(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeCheck,
  input  logic              oddSense,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [DATA_W:0]   inData,
  output logic              outValid,
  output logic [DATA_W:0]   outData,
  output logic              outIsCheck,
  output logic              rowErr,
  output logic              colValid,
  output logic [DATA_W:0]   colSyndrome,
  output logic              frameErr
);
  lrcStrobes_t strobes;

  lrc_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .modeCheck (modeCheck),
    .strobes   (strobes)
  );

  lrc_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .oddSense    (oddSense),
    .inData      (inData),
    .outValid    (outValid),
    .outData     (outData),
    .outIsCheck  (outIsCheck),
    .rowErr      (rowErr),
    .colValid    (colValid),
    .colSyndrome (colSyndrome),
    .frameErr    (frameErr)
  );
endmodule

// File: rtl/lrc_codec_chk.sv
module lrc_codec_chk #(
  parameter int DATA_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            modeCheck,
  input logic            oddSense,
  input logic            outValid,
  input logic [DATA_W:0] outData,
  input logic            outIsCheck,
  input logic            rowErr,
  input logic            colValid,
  input logic [DATA_W:0] colSyndrome,
  input logic            frameErr
);
  // R1: each coded character carries the parity sense of the cycle it was taken
  p_row_parity_r1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIsCheck) |-> ((^outData) == $past(oddSense)));

  // R3: the check character is itself a valid output and lasts one cycle
  p_check_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    outIsCheck |-> (outValid && $past(outValid) && !$past(outIsCheck)));

  // R4: the cycle after the check character carries no output
  p_gap_after_check_r4: assert property (@(posedge clk) disable iff (!rstN)
    outIsCheck |=> !outValid);

  // R7: the column result is a single-cycle pulse
  p_col_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    colValid |=> !colValid);

  // R9: any reported error sets the frame flag at once
  p_err_sets_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rowErr || (colValid && (|colSyndrome))) |-> frameErr);

  // R9: the flag only rises together with a reported error
  p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> (rowErr || (colValid && (|colSyndrome))));

  // R11: check mode never produces coded output
  p_quiet_check_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeCheck) && $past(modeCheck, 2)) |-> !outValid);
endmodule

bind lrc_codec lrc_codec_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .modeCheck   (modeCheck),
  .oddSense    (oddSense),
  .outValid    (outValid),
  .outData     (outData),
  .outIsCheck  (outIsCheck),
  .rowErr      (rowErr),
  .colValid    (colValid),
  .colSyndrome (colSyndrome),
  .frameErr    (frameErr)
);

// File: tb/lrc_codec_tb_top.sv
module lrc_codec_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeCheck = 1'b0;
  logic       oddSense = 1'b0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic [7:0] inData = '0;
  logic       outValid, outIsCheck, rowErr, colValid, frameErr;
  logic [7:0] outData, colSyndrome;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lrc_codec dut_i (
    .clk(clk), .rstN(rstN), .modeCheck(modeCheck), .oddSense(oddSense),
    .inValid(inValid), .inLast(inLast), .inData(inData),
    .outValid(outValid), .outData(outData), .outIsCheck(outIsCheck),
    .rowErr(rowErr), .colValid(colValid), .colSyndrome(colSyndrome),
    .frameErr(frameErr)
  );

  // {sense, 7-bit data, expected coded character}
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 7'b1110001, 8'hF1}, {1'b0, 7'b1110001, 8'h71},
    {1'b1, 7'b0000000, 8'h80}, {1'b0, 7'b0000000, 8'h00},
    {1'b1, 7'b1111111, 8'h7F}, {1'b0, 7'b1111111, 8'hFF},
    {1'b1, 7'b0000001, 8'h01}, {1'b0, 7'b0101010, 8'hAA}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, return on the next one with results visible
  task automatic step(input logic v, input logic l, input logic [7:0] d);
    inValid = v; inLast = l; inData = d;
    @(negedge clk);
  endtask

  function automatic logic [7:0] codeOf(input logic s, input logic [6:0] d);
    int n = 0;
    for (int i = 0; i < 7; i++) n += d[i];
    return {((n % 2) == 1) != s, d};
  endfunction

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] acc;
    logic [7:0] c [3];
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 outValid", outValid, 0);
    chk("R10 outIsCheck", outIsCheck, 0);
    chk("R10 rowErr", rowErr, 0);
    chk("R10 colValid", colValid, 0);
    chk("R10 frameErr", frameErr, 0);
    chk("R10 colSyndrome", colSyndrome, 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: one-character frames, R1 R2 and R3
    for (int k = 0; k < 8; k++) begin
      oddSense = VEC[k][15];
      step(1'b1, 1'b1, {1'b0, VEC[k][14:8]});
      chk("R1 coded valid", outValid, 1);
      chk("R2 coded value", outData, VEC[k][7:0]);
      chk("R1 not check", outIsCheck, 0);
      step(1'b0, 1'b0, 8'h00);
      chk("R3 check flag", outIsCheck, 1);
      chk("R3 check value", outData, VEC[k][7:0] ^ {8{VEC[k][15]}});
      step(1'b0, 1'b0, 8'h00);
      chk("R3 idle after", outValid, 0);
    end

    // R3 R4 three-character odd frame with an input in the dead slot
    oddSense = 1'b1;
    c[0] = codeOf(1, 7'h15); c[1] = codeOf(1, 7'h6C); c[2] = codeOf(1, 7'h33);
    acc = c[0] ^ c[1] ^ c[2] ^ 8'hFF;
    step(1'b1, 1'b0, 8'h15);
    chk("R1 multi c0", outData, c[0]);
    step(1'b1, 1'b0, 8'h6C);
    chk("R1 multi c1", outData, c[1]);
    step(1'b1, 1'b1, 8'h33);
    chk("R1 multi c2", outData, c[2]);
    step(1'b1, 1'b0, 8'h7E);   // dropped
    chk("R4 check after drop", outData, acc);
    chk("R4 check flag", outIsCheck, 1);
    step(1'b0, 1'b0, 8'h00);
    chk("R4 no output for dropped", outValid, 0);

    // R5 next even frame restarts the accumulator
    oddSense = 1'b0;
    step(1'b1, 1'b0, 8'h41);
    step(1'b1, 1'b1, 8'h0F);
    step(1'b0, 1'b0, 8'h00);
    chk("R5 fresh check", outData, codeOf(0, 7'h41) ^ codeOf(0, 7'h0F));
    step(1'b0, 1'b0, 8'h00);

    // check mode, clean odd frame: R6 R7 R11
    modeCheck = 1'b1; oddSense = 1'b1;
    step(1'b1, 1'b0, c[0]);
    chk("R6 clean row", rowErr, 0);
    chk("R11 no output", outValid, 0);
    step(1'b1, 1'b0, c[1]);
    step(1'b1, 1'b0, c[2]);
    step(1'b1, 1'b1, acc);
    chk("R6 check char not row-checked", rowErr, 0);
    chk("R7 colValid", colValid, 1);
    chk("R7 clean syndrome", colSyndrome, 0);
    chk("R9 clean frame", frameErr, 0);
    step(1'b0, 1'b0, 8'h00);
    chk("R7 pulse ends", colValid, 0);

    // single flipped bit 3 in c1
    step(1'b1, 1'b0, c[0]);
    step(1'b1, 1'b0, c[1] ^ 8'h08);
    chk("R6 row error", rowErr, 1);
    chk("R9 flag set", frameErr, 1);
    step(1'b1, 1'b0, c[2]);
    chk("R6 pulse ends", rowErr, 0);
    chk("R9 flag held", frameErr, 1);
    step(1'b1, 1'b1, acc);
    chk("R7 single syndrome", colSyndrome, 8'h08);

    // double error bits 1 and 5 in c1
    step(1'b1, 1'b0, c[0]);
    chk("R9 reload on first", frameErr, 0);
    step(1'b1, 1'b0, c[1] ^ 8'h22);
    chk("R8 row blind", rowErr, 0);
    chk("R8 flag still clear", frameErr, 0);
    step(1'b1, 1'b0, c[2]);
    step(1'b1, 1'b1, acc);
    chk("R8 syndrome", colSyndrome, 8'h22);
    chk("R8 frame flagged", frameErr, 1);
    step(1'b0, 1'b0, 8'h00);
    chk("R9 held idle", frameErr, 1);

    // even-sense check frame whose first character is bad
    oddSense = 1'b0;
    step(1'b1, 1'b0, codeOf(0, 7'h11) ^ 8'h80);
    chk("R9 reload with error", frameErr, 1);
    chk("R6 even row error", rowErr, 1);
    step(1'b1, 1'b1, codeOf(0, 7'h11));
    chk("R7 even syndrome", colSyndrome, 8'h80);
    step(1'b0, 1'b0, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule